// File: doc/BRIEF.md
# BCD Countdown Watchdog Timer

This block is a watchdog that counts down an interval held as four BCD digits: two for whole seconds and two for hundredths of a second. The longest interval is 99.99 s. A 100 Hz tick input drives the count. Software programs the block over a byte-wide register bus with a one-cycle read latency. Any write to either interval register loads the count again, so periodic writes keep the watchdog from expiring.

When the count reaches zero, a sticky expiry flag is set. It stays set until software reads the status register. A steering bit in the control register decides what expiry does. With the bit clear, the flag drives an interrupt line. With the bit set, expiry fires a fixed-length reset pulse and the interrupt line stays low. An interval of zero in both registers means the watchdog never expires.

Top module: `wdog_bcd_timer`

## Requirements
- R1: After reset every register reads 0x00, and both `wd_irq` and `wd_rst` are low.
- R2: Address 0xC holds the hundredths and address 0xD holds the seconds, each as two BCD digits with the tens in bits 7:4. Each reads back exactly as written. The largest interval, 0x99/0x99, expires after 9999 ticks.
- R3: While enabled, each cycle with `tick_100hz` high decrements the count by one, with a decimal borrow from the hundredths into the seconds. Expiry therefore occurs on exactly the N-th tick after loading, where N = 100*seconds + hundredths.
- R4: A write to either interval register loads the count from both registers and restarts the countdown. A write in the same cycle as a tick takes precedence over the tick.
- R5: With both interval registers zero, the watchdog never expires, however many ticks arrive.
- R6: The enable is bit 1 of the control register at 0xF. While it is clear, ticks are ignored and the remaining count is kept.
- R7: The expiry flag is bit 1 of the status register at 0xE. It is set on expiry and stays set until that register is read. The read returns the set flag and clears it.
- R8: With the steering bit (bit 0 of 0xF) clear, `wd_irq` is high exactly while the expiry flag is set.
- R9: With the steering bit set, expiry drives `wd_rst` high for RST_LEN (16) cycles, starting the cycle after the expiring tick, while `wd_irq` stays low.
- R10: `bus_rdata` presents the addressed register one cycle after `bus_rd`. Unmapped addresses and unused bits read zero, and the control register keeps only bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_100hz | input | 1 | One-cycle pulse at 100 Hz |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| wd_irq | output | 1 | Interrupt, high while the flag is set and steering is clear |
| wd_rst | output | 1 | Reset pulse on expiry when steering is set |

## Verification
Random BCD intervals with varied digits in both registers expose a wrong borrow from hundredths into seconds or a miscount by one. The interrupt is checked one tick before the expected expiry and on that tick. Directed cases cover the following:
- the full 99.99 s interval, which tests the widest borrow chain;
- a kick partway through a countdown, and a write that lands on a tick;
- a pause with the enable cleared, which must keep the remaining count rather than reset it;
- an all-zero interval;
- reset steering, where the pulse length is counted at the pin.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int DIGITS  = 4;
    localparam int CNT_W   = 4 * DIGITS;

    localparam logic [ADDR_W-1:0] ADR_HUND = 4'hC;
    localparam logic [ADDR_W-1:0] ADR_SECS = 4'hD;
    localparam logic [ADDR_W-1:0] ADR_STAT = 4'hE;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 4'hF;

    localparam int FLAG_BIT  = 1;
    localparam int EN_BIT    = 1;
    localparam int STEER_BIT = 0;

    typedef struct packed {
        logic en;
        logic steer;
    } wd_ctrl_t;

    typedef struct packed {
        logic       borrow;
        logic [3:0] digit;
    } bcd_step_t;

    // One decimal digit minus an incoming borrow
    function automatic bcd_step_t bcd_digit_dec(input logic [3:0] d, input logic bin);
        bcd_step_t r;
        if (!bin) begin
            r.borrow = 1'b0;
            r.digit  = d;
        end else if (d == 4'd0) begin
            r.borrow = 1'b1;
            r.digit  = 4'd9;
        end else begin
            r.borrow = 1'b0;
            r.digit  = d - 4'd1;
        end
        return r;
    endfunction
endpackage

// File: rtl/wdog_bcd_down.sv
module wdog_bcd_down
    import wdog_pkg::*;
#(
    parameter int NDIG = DIGITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              run,
    input  logic              load,
    input  logic [4*NDIG-1:0] load_val,
    output logic [4*NDIG-1:0] count,
    output logic              expire
);
    localparam int W = 4 * NDIG;
    localparam logic [W-1:0] ONE = W'(1);

    logic [NDIG:0] brw;
    logic [W-1:0]  dec_val;
    logic          step;

    assign brw[0] = 1'b1;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        bcd_step_t st;
        assign st             = bcd_digit_dec(count[4*g +: 4], brw[g]);
        assign dec_val[4*g +: 4] = st.digit;
        assign brw[g+1]       = st.borrow;
    end

    assign step   = tick && run && (count != '0) && !load;
    assign expire = step && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;
        else if (step) count <= dec_val;
    end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              expire,
    output logic [BYTE_W-1:0] rdata,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output wd_ctrl_t          ctrl,
    output logic              flag
);
    logic [BYTE_W-1:0] hund_q, secs_q, rd_mux;
    logic wr_hund, wr_secs, wr_ctrl, rd_stat;

    assign wr_hund = wr && (addr == ADR_HUND);
    assign wr_secs = wr && (addr == ADR_SECS);
    assign wr_ctrl = wr && (addr == ADR_CTRL);
    assign rd_stat = rd && (addr == ADR_STAT);

    assign load     = wr_hund || wr_secs;
    assign load_val = {(wr_secs ? wdata : secs_q), (wr_hund ? wdata : hund_q)};

    always_ff @(posedge clk) begin
        if (rst) begin
            hund_q <= '0;
            secs_q <= '0;
            ctrl   <= '0;
        end else begin
            if (wr_hund) hund_q <= wdata;
            if (wr_secs) secs_q <= wdata;
            if (wr_ctrl) begin
                ctrl.en    <= wdata[EN_BIT];
                ctrl.steer <= wdata[STEER_BIT];
            end
        end
    end

    // Expiry beats a clearing read in the same cycle
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (expire)  flag <= 1'b1;
        else if (rd_stat) flag <= 1'b0;
    end

    always_comb begin
        rd_mux = '0;
        case (addr)
            ADR_HUND: rd_mux = hund_q;
            ADR_SECS: rd_mux = secs_q;
            ADR_STAT: rd_mux[FLAG_BIT] = flag;
            ADR_CTRL: begin
                rd_mux[EN_BIT]    = ctrl.en;
                rd_mux[STEER_BIT] = ctrl.steer;
            end
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LEN_C = CW'(LEN);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                remain <= '0;
        else if (fire)          remain <= LEN_C;
        else if (remain != '0)  remain <= remain - 1'b1;
    end

    assign pulse = (remain != '0);
endmodule

// File: rtl/wdog_bcd_timer.sv
module wdog_bcd_timer
    import wdog_pkg::*;
#(
    parameter int RST_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_100hz,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              wd_irq,
    output logic              wd_rst
);
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_load_val;
    logic [CNT_W-1:0] cnt_value;
    logic             cnt_expire;
    logic             wd_flag;
    wd_ctrl_t         ctrl;

    wdog_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .expire   (cnt_expire),
        .rdata    (bus_rdata),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .ctrl     (ctrl),
        .flag     (wd_flag)
    );

    wdog_bcd_down #(.NDIG(DIGITS)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_100hz),
        .run      (ctrl.en),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .count    (cnt_value),
        .expire   (cnt_expire)
    );

    wdog_pulse #(.LEN(RST_LEN)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (cnt_expire && ctrl.steer),
        .pulse (wd_rst)
    );

    assign wd_irq = wd_flag && !ctrl.steer;
endmodule

// File: rtl/wdog_bcd_timer_chk.sv
module wdog_bcd_timer_chk
    import wdog_pkg::*;
#(
    parameter int RST_LEN = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              load,
    input logic [CNT_W-1:0]  load_val,
    input logic [CNT_W-1:0]  count,
    input logic              expire,
    input logic              flag,
    input logic              wd_rst
);
    int unsigned hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)         hi_cnt <= 0;
        else if (wd_rst) hi_cnt <= hi_cnt + 1;
        else             hi_cnt <= 0;
    end

    a_r4_reload_takes_value: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_val)));

    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(count));

    a_r5_zero_never_expires: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !expire);

    a_r7_flag_sets: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !(bus_rd && bus_addr == ADR_STAT)) |=> flag);

    a_r9_pulse_after_expiry: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_rst) |-> $past(expire));

    a_r9_pulse_length: assert property (@(posedge clk) disable iff (rst)
        $fell(wd_rst) |-> (hi_cnt >= RST_LEN));
endmodule

bind wdog_bcd_timer wdog_bcd_timer_chk #(.RST_LEN(RST_LEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_100hz),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .count    (cnt_value),
    .expire   (cnt_expire),
    .flag     (wd_flag),
    .wd_rst   (wd_rst)
);

// File: tb/wdog_bcd_timer_bench.sv
`timescale 1ns/1ps
module wdog_bcd_timer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_100hz = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wd_irq;
    logic       wd_rst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdog_bcd_timer #(.RST_LEN(16)) u_wdog_bcd_timer (
        .clk(clk), .rst(rst), .tick_100hz(tick_100hz),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wd_irq(wd_irq), .wd_rst(wd_rst)
    );

    function automatic int bcd_ticks(input logic [7:0] s, input logic [7:0] h);
        return 1000 * int'(s[7:4]) + 100 * int'(s[3:0]) + 10 * int'(h[7:4]) + int'(h[3:0]);
    endfunction

    function automatic logic [7:0] ctrl_view(input logic [7:0] d);
        return {6'b0, d[1:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_100hz = 1'b1;
            @(negedge clk);
        end
        tick_100hz = 1'b0;
    endtask

    task automatic load_iv(input logic [7:0] s, input logic [7:0] h);
        wr_reg(4'hC, h);
        wr_reg(4'hD, s);
    endtask

    task automatic clear_flag(input string req);
        logic [7:0] d;
        rd_reg(4'hE, d);
        chk({req, " status read shows flag"}, d, 8'h02);
        chk({req, " irq low after clearing read"}, wd_irq, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog timeout actual running expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] s, h;
        int n;
        void'($urandom(32'd1511));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_reg(4'hC, d); chk("R1 hund reset", d, 8'h00);
        rd_reg(4'hD, d); chk("R1 secs reset", d, 8'h00);
        rd_reg(4'hE, d); chk("R1 status reset", d, 8'h00);
        rd_reg(4'hF, d); chk("R1 ctrl reset", d, 8'h00);
        chk("R1 irq reset", wd_irq, 1'b0);
        chk("R1 rst reset", wd_rst, 1'b0);

        // R10 control masking and unmapped address
        wr_reg(4'hF, 8'hFF);
        rd_reg(4'hF, d); chk("R10 ctrl keeps bits 1:0", d, ctrl_view(8'hFF));
        wr_reg(4'h3, 8'h5A);
        rd_reg(4'h3, d); chk("R10 unmapped reads zero", d, 8'h00);
        wr_reg(4'hF, 8'h02);

        // R3 / R8 basic 00.03 interval
        load_iv(8'h00, 8'h03);
        ticks(2); chk("R3 no expiry before last tick", wd_irq, 1'b0);
        ticks(1); chk("R8 irq on expiry", wd_irq, 1'b1);
        rd_reg(4'hE, d); chk("R7 status shows flag", d, 8'h02);
        chk("R7 flag cleared by read", wd_irq, 1'b0);
        rd_reg(4'hE, d); chk("R7 second read is zero", d, 8'h00);

        // R7 flag sticks across idle time and further ticks
        load_iv(8'h00, 8'h01);
        ticks(1);
        ticks(20);
        chk("R7 flag sticky", wd_irq, 1'b1);
        clear_flag("R7");

        // R3 random BCD intervals
        for (int k = 0; k < 8; k++) begin
            s = {4'd0, 4'($urandom_range(0, 2))};
            h = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
            if (s == 0 && h == 0) h = 8'h10;
            n = bcd_ticks(s, h);
            load_iv(s, h);
            ticks(n - 1); chk("R3 random no early expiry", wd_irq, 1'b0);
            ticks(1);     chk("R3 random expiry on N-th tick", wd_irq, 1'b1);
            clear_flag("R3");
        end

        // R3 borrow boundary 01.00
        load_iv(8'h01, 8'h00);
        ticks(99);  chk("R3 borrow 01.00 not early", wd_irq, 1'b0);
        ticks(1);   chk("R3 borrow 01.00 expiry", wd_irq, 1'b1);
        clear_flag("R3");

        // R2 maximum interval and read back
        load_iv(8'h99, 8'h99);
        rd_reg(4'hC, d); chk("R2 hund readback", d, 8'h99);
        rd_reg(4'hD, d); chk("R2 secs readback", d, 8'h99);
        ticks(9998); chk("R2 max not early", wd_irq, 1'b0);
        ticks(1);    chk("R2 max expiry at 9999", wd_irq, 1'b1);
        clear_flag("R2");

        // R4 kick mid-countdown
        load_iv(8'h00, 8'h05);
        ticks(4);
        wr_reg(4'hC, 8'h05);
        ticks(4); chk("R4 kick restarts count", wd_irq, 1'b0);
        ticks(1); chk("R4 expiry after kick", wd_irq, 1'b1);
        clear_flag("R4");

        // R4 write and tick in the same cycle: write wins
        load_iv(8'h00, 8'h03);
        bus_addr = 4'hC; bus_wdata = 8'h02; bus_wr = 1'b1; tick_100hz = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_100hz = 1'b0;
        ticks(1); chk("R4 write beats tick", wd_irq, 1'b0);
        ticks(1); chk("R4 expiry from written value", wd_irq, 1'b1);
        clear_flag("R4");

        // R6 disable keeps remaining count
        load_iv(8'h00, 8'h05);
        ticks(2);
        wr_reg(4'hF, 8'h00);
        ticks(10); chk("R6 disabled ignores ticks", wd_irq, 1'b0);
        wr_reg(4'hF, 8'h02);
        ticks(2); chk("R6 remaining count kept", wd_irq, 1'b0);
        ticks(1); chk("R6 expiry after resume", wd_irq, 1'b1);
        clear_flag("R6");

        // R5 zero interval never expires
        load_iv(8'h00, 8'h00);
        ticks(150);
        chk("R5 zero interval irq", wd_irq, 1'b0);
        rd_reg(4'hE, d); chk("R5 zero interval flag", d, 8'h00);

        // R9 reset steering
        wr_reg(4'hF, 8'h03);
        load_iv(8'h00, 8'h02);
        ticks(1); chk("R9 no pulse before expiry", wd_rst, 1'b0);
        tick_100hz = 1'b1;
        @(negedge clk);
        tick_100hz = 1'b0;
        n = 0;
        for (int i = 0; i < 24; i++) begin
            if (wd_rst) n++;
            if (wd_irq) chk("R9 irq low when steered", wd_irq, 1'b0);
            @(negedge clk);
        end
        chk("R9 pulse length", n, 16);
        chk("R9 pulse ended", wd_rst, 1'b0);
        rd_reg(4'hE, d); chk("R9 flag set on steered expiry", d, 8'h02);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule